// File: doc/BRIEF.md
# Paged display memory with row scanout

This block is the pixel store of a small monochrome dot-matrix panel controller. It holds a grid of 102 columns by 66 rows, one bit per dot. The grid is organised so that a host writes or reads it one byte at a time. A set-page strobe picks a group of rows and a set-column strobe picks a column. Each byte covers eight vertically stacked dots of one column. Two trailing pages hold a single row each: the 65th display line and an icon row. A data-order input picks whether bit 7 or bit 0 of a byte sits at the top of its page.

A second, independent port feeds the panel's line latch. Each line-tick pulse makes the scanner hand out one complete 102-bit row, together with its row number, one cycle later. It walks rows 0 to 65 and then starts again, so the icon row always goes out in the last line period of a frame. Host accesses can happen in any cycle while scanning runs. A scan that hits a row being written in the same cycle returns the contents from before that write.

Top module: `lcd_page_ram`

## Requirements
- R1: After reset, rd_data is 0, row_valid is 0, the page register is 0, the column register is 0 and the scan line counter is 0.
- R2: With order = 0, a byte access to page p (0 to 7) maps data bit k to row 8*p + 7 - k, so bit 7 is the top row of the page.
- R3: With order = 1, a byte access to page p (0 to 7) maps data bit k to row 8*p + k, so bit 0 is the top row of the page.
- R4: Page 8 holds only row 64 and page 9 holds only row 65 (the icon row). For these pages only bit 7 (order = 0) or bit 0 (order = 1) is stored on a write and returned on a read; the other write bits are ignored and the other read bits are 0.
- R5: After every accepted byte write or read the column register advances by one, but it stays at 101 once it holds 101.
- R6: A write or read while the page register is above 9 or the column register is above 101 is ignored: no memory bit changes, rd_data keeps its value and the column register does not move.
- R7: A line_tick in cycle n makes row_valid high for exactly cycle n+1, with row_index equal to the line counter and row_data equal to that whole row. The counter then steps by one, wrapping from 65 to 0, so row 65 (the icon row) goes out in the last line period of each frame.
- R8: When a byte write and a scan transfer touch the same row in the same cycle, the scan returns the row as it was before the write, and the write is still stored.
- R9: rd_data changes only in the cycle after an accepted read. A read strobe raised in the same cycle as a write strobe is ignored, because the write takes priority.
- R10: The page register changes only on set_page, which loads addr_in[3:0]. set_col loads addr_in[6:0] into the column register, and a strobe overrides the auto-increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order | input | 1 | Data-order mode: 0 puts bit 7 on top, 1 puts bit 0 on top |
| set_page | input | 1 | Load the page register from addr_in[3:0] |
| set_col | input | 1 | Load the column register from addr_in |
| addr_in | input | 7 | Address value for the set strobes |
| wr_en | input | 1 | Byte write at the current page and column |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Byte read at the current page and column |
| rd_data | output | 8 | Last byte read, registered |
| line_tick | input | 1 | Start of a line period |
| row_valid | output | 1 | One-cycle strobe for a row transfer |
| row_index | output | 7 | Row number being transferred |
| row_data | output | 102 | Full row contents, one bit per column |

## Verification
The assertions assume that reset is held for at least one clock before any strobe, and that line_tick stays low while reset is held. They also assume the host never raises set_page or set_col in the same cycle as a byte access, which the stimulus never does. No check relies on memory contents the host has not yet written: the bench loads every page before the first read of a full page and before the first line tick. Every host access and every tick is driven at the falling edge, and the bench compares its behavioural model against the ports one unit of time after each rising edge.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
   localparam int PAGE_H = 8;
   localparam int PG_W   = 4;

   typedef struct packed {
      logic       ok;
      logic [7:0] row;
   } lane_t;

   // Map one data lane of a byte access to a row of the grid.
   function automatic lane_t lane_map(input int page, input int lane,
                                      input logic order, input int full_pages);
      lane_t m;
      if (page < full_pages) begin
         m.ok  = 1'b1;
         m.row = 8'(page * PAGE_H + (order ? lane : PAGE_H - 1 - lane));
      end else begin
         m.ok  = order ? (lane == 0) : (lane == PAGE_H - 1);
         m.row = 8'(full_pages * PAGE_H + ((page == full_pages) ? 0 : 1));
      end
      return m;
   endfunction
endpackage

// File: rtl/lpr_addr.sv
module lpr_addr
   import lpr_pkg::*;
#(
   parameter int COLS       = 102,
   parameter int FULL_PAGES = 8,
   localparam int COL_W     = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_page,
   input  logic             set_col,
   input  logic [COL_W-1:0] addr_in,
   input  logic             wr_en,
   input  logic             rd_en,
   output logic [PG_W-1:0]  page_q,
   output logic [COL_W-1:0] col_q,
   output logic             do_wr,
   output logic             do_rd
);
   localparam int LAST_PAGE = FULL_PAGES + 1;
   logic addr_ok;

   assign addr_ok = (int'(page_q) <= LAST_PAGE) && (int'(col_q) <= COLS - 1);
   assign do_wr   = wr_en && addr_ok;
   assign do_rd   = rd_en && !wr_en && addr_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         col_q  <= '0;
      end else begin
         if (set_page) page_q <= addr_in[PG_W-1:0];
         if (set_col)
            col_q <= addr_in;
         else if ((do_wr || do_rd) && int'(col_q) != COLS - 1)
            col_q <= col_q + 1'b1;
      end
   end

   assert_col_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((do_wr || do_rd) && int'(col_q) == COLS - 1 && !set_col) |=> int'(col_q) == COLS - 1);
   assert_bad_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && !addr_ok && !set_col) |=> $stable(col_q));
   assert_page_only_on_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !set_page |=> $stable(page_q));
endmodule

// File: rtl/lpr_array.sv
module lpr_array
   import lpr_pkg::*;
#(
   parameter int COLS       = 102,
   parameter int FULL_PAGES = 8,
   localparam int ROWS      = FULL_PAGES * PAGE_H + 2,
   localparam int IDX_W     = $clog2(ROWS),
   localparam int COL_W     = $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_wr,
   input  logic              do_rd,
   input  logic              order,
   input  logic [PG_W-1:0]   page,
   input  logic [COL_W-1:0]  col,
   input  logic [PAGE_H-1:0] wr_data,
   input  logic              scan_req,
   input  logic [IDX_W-1:0]  scan_idx,
   output logic [PAGE_H-1:0] rd_data,
   output logic [COLS-1:0]   row_data
);
   logic [COLS-1:0]  mem [ROWS];
   logic [IDX_W-1:0] lane_row [PAGE_H];
   logic [PAGE_H-1:0] lane_ok;

   for (genvar k = 0; k < PAGE_H; k++) begin : g_lane
      lane_t m;
      always_comb begin
         m           = lane_map(int'(page), k, order, FULL_PAGES);
         lane_ok[k]  = m.ok;
         lane_row[k] = IDX_W'(m.row);
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr)
         for (int k = 0; k < PAGE_H; k++)
            if (lane_ok[k]) mem[lane_row[k]][col] <= wr_data[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         row_data <= '0;
      end else begin
         if (do_rd)
            for (int k = 0; k < PAGE_H; k++)
               rd_data[k] <= lane_ok[k] & mem[lane_row[k]][col];
         if (scan_req) row_data <= mem[scan_idx];
      end
   end

   assert_rd_only_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !do_rd |=> $stable(rd_data));
endmodule

// File: rtl/lpr_scan.sv
module lpr_scan #(
   parameter int ROWS   = 66,
   localparam int IDX_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_tick,
   output logic             scan_req,
   output logic [IDX_W-1:0] scan_idx,
   output logic             row_valid,
   output logic [IDX_W-1:0] row_index
);
   logic [IDX_W-1:0] line_q;

   assign scan_req = line_tick;
   assign scan_idx = line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q    <= '0;
         row_valid <= 1'b0;
         row_index <= '0;
      end else begin
         row_valid <= line_tick;
         if (line_tick) begin
            row_index <= line_q;
            line_q    <= (int'(line_q) == ROWS - 1) ? '0 : line_q + 1'b1;
         end
      end
   end

   assert_valid_follows_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid |-> $past(line_tick));
   assert_index_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid |-> int'(row_index) < ROWS);
   assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && int'(line_q) == ROWS - 1) |=> line_q == '0);
endmodule

// File: rtl/lcd_page_ram.sv
module lcd_page_ram
   import lpr_pkg::*;
#(
   parameter int COLS       = 102,
   parameter int FULL_PAGES = 8,
   localparam int ROWS      = FULL_PAGES * PAGE_H + 2,
   localparam int IDX_W     = $clog2(ROWS),
   localparam int COL_W     = $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              order,
   input  logic              set_page,
   input  logic              set_col,
   input  logic [COL_W-1:0]  addr_in,
   input  logic              wr_en,
   input  logic [PAGE_H-1:0] wr_data,
   input  logic              rd_en,
   output logic [PAGE_H-1:0] rd_data,
   input  logic              line_tick,
   output logic              row_valid,
   output logic [IDX_W-1:0]  row_index,
   output logic [COLS-1:0]   row_data
);
   if (FULL_PAGES < 1 || FULL_PAGES + 2 > (1 << PG_W)) begin : g_bad_pages
      $error("FULL_PAGES does not fit the page register");
   end
   if (COLS < 2 || COL_W < PG_W) begin : g_bad_cols
      $error("COLS too small for the shared address input");
   end

   logic [PG_W-1:0]  page_q;
   logic [COL_W-1:0] col_q;
   logic             do_wr, do_rd, scan_req;
   logic [IDX_W-1:0] scan_idx;

   lpr_addr #(.COLS(COLS), .FULL_PAGES(FULL_PAGES)) u_addr (
      .clk, .rst_n, .set_page, .set_col, .addr_in, .wr_en, .rd_en,
      .page_q, .col_q, .do_wr, .do_rd
   );

   lpr_array #(.COLS(COLS), .FULL_PAGES(FULL_PAGES)) u_array (
      .clk, .rst_n, .do_wr, .do_rd, .order, .page(page_q), .col(col_q),
      .wr_data, .scan_req, .scan_idx, .rd_data, .row_data
   );

   lpr_scan #(.ROWS(ROWS)) u_scan (
      .clk, .rst_n, .line_tick, .scan_req, .scan_idx, .row_valid, .row_index
   );
endmodule

// File: tb/lcd_page_ram_bench.sv
`timescale 1ns/1ps
module lcd_page_ram_bench;
   logic clk = 0, rst_n = 0, order = 0;
   logic set_page = 0, set_col = 0, wr_en = 0, rd_en = 0, line_tick = 0;
   logic [6:0] addr_in = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] rd_data;
   logic row_valid;
   logic [6:0] row_index;
   logic [101:0] row_data;

   always #2.5 clk = ~clk;

   lcd_page_ram u_lcd_page_ram (.*);

   int checks = 0, errors = 0;
   bit done = 0;

   // reference state
   logic [101:0] em [66];
   int mp = 0, mc = 0, ml = 0;
   logic [7:0] erd = 0;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void mapb(input int p, input int k, input bit o, output bit v, output int r);
      if (p < 8) begin v = 1; r = o ? p * 8 + k : p * 8 + 7 - k; end
      else begin v = o ? (k == 0) : (k == 7); r = (p == 8) ? 64 : 65; end
   endfunction

   task automatic step(input bit sp, input bit sc, input int a, input bit wr, input int wd,
                       input bit rd, input bit tk, input string tag);
      bit ev, ok, v; int r; int ei; logic [101:0] er;
      @(negedge clk);
      set_page = sp; set_col = sc; addr_in = 7'(a); wr_en = wr; wr_data = 8'(wd);
      rd_en = rd; line_tick = tk;
      @(posedge clk); #1;
      ev = tk; er = '0; ei = 0;
      if (tk) begin er = em[ml]; ei = ml; ml = (ml == 65) ? 0 : ml + 1; end
      ok = (mp <= 9) && (mc <= 101);
      if (wr && ok) begin
         for (int k = 0; k < 8; k++) begin mapb(mp, k, order, v, r); if (v) em[r][mc] = wd[k]; end
         if (mc < 101) mc++;
      end else if (rd && ok) begin
         erd = 0;
         for (int k = 0; k < 8; k++) begin mapb(mp, k, order, v, r); if (v) erd[k] = em[r][mc]; end
         if (mc < 101) mc++;
      end
      if (sp) mp = a % 16;
      if (sc) mc = a % 128;
      chk(rd_data === erd, tag, 128'(rd_data), 128'(erd));
      chk(row_valid === ev, "R7 row_valid", 128'(row_valid), 128'(ev));
      if (ev) begin
         chk(row_data === er, tk && wr ? "R8 row_data" : "R7 row_data", 128'(row_data), 128'(er));
         chk(int'(row_index) == ei, "R7 row_index", 128'(row_index), 128'(ei));
      end
   endtask

   task automatic setpc(input int p, input int c);
      step(1, 0, p, 0, 0, 0, 0, "R10");
      step(0, 1, c, 0, 0, 0, 0, "R10");
   endtask

   task automatic rdb(input string tag);
      step(0, 0, 0, 0, 0, 1, 0, tag);
   endtask

   initial begin
      for (int i = 0; i < 66; i++) em[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;
      chk(rd_data === 8'h00, "R1 rd_data", 128'(rd_data), 0);
      chk(row_valid === 1'b0, "R1 row_valid", 128'(row_valid), 0);
      // R1: reset address is page 0 column 0
      step(0, 0, 0, 1, 8'hC3, 0, 0, "R1");
      step(0, 1, 0, 0, 0, 0, 0, "R1");
      rdb("R1 reset address");
      // fill every page in order 0
      for (int p = 0; p < 10; p++) begin
         setpc(p, 0);
         for (int c = 0; c < 102; c++) step(0, 0, 0, 1, ((p * 37 + c * 11) ^ 8'h5A) & 255, 0, 0, "R2");
      end
      // R2 reads in order 0
      for (int p = 0; p < 10; p++) begin
         setpc(p, (p * 9) % 100);
         rdb(p < 8 ? "R2 order0 read" : "R4 partial read");
         rdb(p < 8 ? "R2 order0 read" : "R4 partial read");
      end
      // R3 reversed order
      order = 1;
      for (int p = 0; p < 10; p++) begin
         setpc(p, 5 + p);
         rdb(p < 8 ? "R3 order1 read" : "R4 partial read");
         setpc(p, 40 + p);
         step(0, 0, 0, 1, 8'h96 + p, 0, 0, "R3");
         step(0, 1, 40 + p, 0, 0, 0, 0, "R3");
         rdb(p < 8 ? "R3 readback" : "R4 partial readback");
      end
      order = 0;
      for (int p = 0; p < 10; p++) begin
         setpc(p, 40 + p);
         rdb(p < 8 ? "R3 cross-order" : "R4 cross-order");
      end
      // R5 saturation
      setpc(2, 100);
      step(0, 0, 0, 1, 8'h11, 0, 0, "R5");
      step(0, 0, 0, 1, 8'h22, 0, 0, "R5");
      step(0, 0, 0, 1, 8'h33, 0, 0, "R5");
      step(0, 1, 101, 0, 0, 0, 0, "R5");
      rdb("R5 saturated column");
      rdb("R5 saturated column");
      // R6 out-of-range page and column
      setpc(12, 3);
      step(0, 0, 0, 1, 8'hFF, 0, 0, "R6");
      rdb("R6 bad page read ignored");
      setpc(3, 120);
      step(0, 0, 0, 1, 8'h00, 0, 0, "R6");
      rdb("R6 bad column read ignored");
      setpc(3, 3);
      rdb("R6 untouched byte");
      // R9 write wins over read
      setpc(4, 7);
      step(0, 0, 0, 1, 8'h3C, 1, 0, "R9 read ignored on write");
      step(0, 1, 7, 0, 0, 0, 0, "R9");
      rdb("R9 write stored");
      // R7 and R8: two frames of ticks, with writes hitting the scanned row
      for (int t = 0; t < 140; t++) begin
         int row = ml;
         if (t % 7 == 3 && row < 64) begin
            step(1, 0, row / 8, 0, 0, 0, 0, "R10");
            step(0, 1, (t * 13) % 102, 0, 0, 0, 0, "R10");
            step(0, 0, 0, 1, t & 255, 0, 1, "R8 concurrent write");
         end else if (t % 11 == 5) begin
            step(0, 0, 0, 0, 0, 0, 1, "R7");
            step(0, 0, 0, 0, 0, 0, 0, "R7");
         end else begin
            step(0, 0, 0, 0, 0, 0, 1, "R7");
         end
      end
      // icon row written during its own transfer
      while (ml != 65) step(0, 0, 0, 0, 0, 0, 1, "R7");
      setpc(9, 50);
      step(0, 0, 0, 1, 8'h80, 0, 1, "R8 icon row");
      while (ml != 0) step(0, 0, 0, 0, 0, 0, 1, "R7");
      repeat (66) step(0, 0, 0, 0, 0, 0, 1, "R7 frame");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule